// File: doc/BRIEF.md
# Codec serial port with clock dividers

This block is the digital side of a codec's synchronous serial link. The input clock first passes a programmable divider to make the device master clock. A second divider makes a serial bit strobe at one, two, four or eight master-clock periods. Every 256 master-clock periods a sample event fires. At that event the block takes the newest ADC word into a single 16-bit shift register and starts a frame on its own: one frame-sync slot, then sixteen bit slots.

In each bit slot the register shifts its top bit out on `sdo_o`. It shifts the host's `sdi_i` in at the bottom. Transmit and receive therefore share the same storage, and the host never starts a transfer. When the sixteenth bit has arrived, the received word is routed by the current port mode. It either becomes a control write or a DAC sample. Control writes can update the mode field and the clock-divider fields. `sclk_o` is a one-cycle strobe at the end of each serial slot. The host samples `sdo_o` and presents `sdi_i` for that strobe.

Top module: `codec_sport`

## Requirements
- R1: After reset the mode field is 0 (control), the serial rate select is 0, the master divider code is 0, and `fs_o`, `dac_valid_o` and `dac_data_o` are all 0.
- R2: `adc_strobe_o` pulses once every 256*N input clock cycles. N is 1, 2, 3, 4 or 5 for master divider codes 0 to 4, and N is 1 for codes 5 to 7.
- R3: Within a frame, consecutive `sclk_o` strobes are N*2^S input cycles apart, where S is the serial rate select (0 to 3).
- R4: After each `adc_strobe_o`, `fs_o` is high for one serial slot. Then `sdo_o` presents, MSB first, the 16-bit `adc_word_i` value captured at the strobe. Changes to `adc_word_i` after the strobe do not alter the frame.
- R5: In each of the 16 bit slots, `sdi_i` is sampled at the slot's `sclk_o` strobe, MSB first, forming the received word.
- R6: With mode bit 0 clear, each received word is a control write. Bits 10:8 select a register. Register 0 takes bits 1:0 as the mode. Register 1 takes bits 3:2 as the serial rate select and bits 6:4 as the master divider code. Other selects change nothing. No DAC sample is produced.
- R7: With mode 01 (data), each received word appears unchanged on `dac_data_o` with a one-cycle `dac_valid_o`, and the mode and clock fields stay unchanged.
- R8: With mode 11 (mixed), a received word with bit 15 set is a control write as in R6. A word with bit 15 clear yields `dac_data_o` = bits 14:0 shifted left by one, with a zero LSB, and a one-cycle `dac_valid_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| adc_word_i | input | 16 | Newest ADC sample, captured at each sample event |
| sdi_i | input | 1 | Serial data from the host |
| adc_strobe_o | output | 1 | One-cycle sample event pulse |
| sclk_o | output | 1 | One-cycle strobe ending each serial slot |
| fs_o | output | 1 | Frame sync, high for the slot before the first bit |
| sdo_o | output | 1 | Serial data to the host, MSB first |
| dac_data_o | output | 16 | Last DAC sample received |
| dac_valid_o | output | 1 | One-cycle pulse when `dac_data_o` updates |
| mode_o | output | 2 | Port mode field |
| sclk_sel_o | output | 2 | Serial rate select field |
| mdiv_code_o | output | 3 | Master divider code field |

## Verification
At the fastest serial rate, a serial slot ends on every master-clock tick, so the sample event always lands on the same cycle as a serial strobe. At the event the register must reload and restart the frame, and the coinciding strobe must neither shift nor appear on `sclk_o`. The sweep over all divider codes and rate selects provokes this coincidence and the slower cases alike. In each case the whole transmitted word, captured at the first strobe after frame sync, is compared against the ADC value that was present at the event.

// File: rtl/codec_sp_pkg.sv
package codec_sp_pkg;
  localparam int WORD_W = 16;

  localparam logic [1:0] MODE_CTRL  = 2'b00;
  localparam logic [1:0] MODE_DATA  = 2'b01;
  localparam logic [1:0] MODE_MIXED = 2'b11;

  function automatic logic [2:0] mdiv_ratio(input logic [2:0] code);
    case (code)
      3'd1:    return 3'd2;
      3'd2:    return 3'd3;
      3'd3:    return 3'd4;
      3'd4:    return 3'd5;
      default: return 3'd1;
    endcase
  endfunction

  function automatic logic [3:0] sclk_ratio(input logic [1:0] sel);
    return 4'd1 << sel;
  endfunction
endpackage

// File: rtl/codec_sp_clkgen.sv
module codec_sp_clkgen
  import codec_sp_pkg::*;
#(
  parameter int EVT_DIV = 256
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] mdiv_code_i,
  input  logic [1:0] sclk_sel_i,
  output logic       evt_o,
  output logic       sclk_tick_o
);
  localparam int EVT_W = $clog2(EVT_DIV);

  logic [2:0]       mdiv_cnt;
  logic [2:0]       mratio;
  logic             dm_tick;
  logic [EVT_W-1:0] evt_cnt;
  logic [2:0]       sdiv_cnt;
  logic [3:0]       sratio;
  logic             tick_raw;

  assign mratio   = mdiv_ratio(mdiv_code_i);
  assign sratio   = sclk_ratio(sclk_sel_i);
  // >= keeps counters sane when a ratio shrinks mid-count
  assign dm_tick  = (mdiv_cnt >= (mratio - 3'd1));
  assign evt_o    = dm_tick && (evt_cnt == EVT_W'(EVT_DIV - 1));
  assign tick_raw = dm_tick && ({1'b0, sdiv_cnt} >= (sratio - 4'd1));
  // event owns its cycle: no serial strobe on it
  assign sclk_tick_o = tick_raw && !evt_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mdiv_cnt <= '0;
      evt_cnt  <= '0;
      sdiv_cnt <= '0;
    end else begin
      mdiv_cnt <= dm_tick ? 3'd0 : mdiv_cnt + 3'd1;
      if (dm_tick) begin
        evt_cnt <= evt_o ? '0 : evt_cnt + 1'b1;
      end
      if (evt_o) begin
        sdiv_cnt <= '0;
      end else if (dm_tick) begin
        sdiv_cnt <= tick_raw ? 3'd0 : sdiv_cnt + 3'd1;
      end
    end
  end

  a_r2_evt_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o |=> !evt_o);
endmodule

// File: rtl/codec_sp_shifter.sv
module codec_sp_shifter
  import codec_sp_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         evt_i,
  input  logic         sclk_tick_i,
  input  logic [W-1:0] adc_i,
  input  logic         sdi_i,
  output logic         fs_o,
  output logic         sdo_o,
  output logic [W-1:0] rx_word_o,
  output logic         rx_valid_o
);
  localparam int SLOT_W = $clog2(W + 2);
  localparam logic [SLOT_W-1:0] SLOT_FS   = SLOT_W'(1);
  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(W + 1);

  // slot 0 idle, 1 frame sync, 2..W+1 data bits
  logic [SLOT_W-1:0] slot;
  logic [W-1:0]      shreg;
  logic [W-1:0]      shifted;
  logic              in_bits;

  assign shifted = {shreg[W-2:0], sdi_i};
  assign in_bits = (slot > SLOT_FS);
  assign fs_o    = (slot == SLOT_FS);
  assign sdo_o   = in_bits && shreg[W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot       <= '0;
      shreg      <= '0;
      rx_word_o  <= '0;
      rx_valid_o <= 1'b0;
    end else begin
      rx_valid_o <= 1'b0;
      if (evt_i) begin
        // new event drops any partial word
        shreg <= adc_i;
        slot  <= SLOT_FS;
      end else if (sclk_tick_i && slot != '0) begin
        if (in_bits) begin
          shreg <= shifted;
        end
        if (slot == SLOT_LAST) begin
          rx_word_o  <= shifted;
          rx_valid_o <= 1'b1;
          slot       <= '0;
        end else begin
          slot <= slot + 1'b1;
        end
      end
    end
  end

  a_r4_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i |=> (fs_o && shreg == $past(adc_i)));
  a_r5_commit_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_valid_o) |-> $past(sclk_tick_i));
endmodule

// File: rtl/codec_sp_router.sv
module codec_sp_router
  import codec_sp_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] rx_word_i,
  input  logic         rx_valid_i,
  output logic [1:0]   mode_o,
  output logic [1:0]   sclk_sel_o,
  output logic [2:0]   mdiv_code_o,
  output logic [W-1:0] dac_data_o,
  output logic         dac_valid_o
);
  logic         is_ctrl;
  logic [W-1:0] dac_next;

  assign is_ctrl  = !mode_o[0] || (mode_o[1] && rx_word_i[W-1]);
  assign dac_next = mode_o[1] ? {rx_word_i[W-2:0], 1'b0} : rx_word_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o      <= MODE_CTRL;
      sclk_sel_o  <= '0;
      mdiv_code_o <= '0;
      dac_data_o  <= '0;
      dac_valid_o <= 1'b0;
    end else begin
      dac_valid_o <= 1'b0;
      if (rx_valid_i) begin
        if (is_ctrl) begin
          case (rx_word_i[10:8])
            3'd0: mode_o <= rx_word_i[1:0];
            3'd1: begin
              sclk_sel_o  <= rx_word_i[3:2];
              mdiv_code_o <= rx_word_i[6:4];
            end
            default: ;
          endcase
        end else begin
          dac_data_o  <= dac_next;
          dac_valid_o <= 1'b1;
        end
      end
    end
  end

  a_r7_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dac_valid_o |=> !dac_valid_o);
  a_r7_regs_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && mode_o == MODE_DATA) |=>
      ($stable(mode_o) && $stable(sclk_sel_o) && $stable(mdiv_code_o)));
  a_r6_ctrl_no_dac: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && mode_o == MODE_CTRL) |=> !dac_valid_o);
endmodule

// File: rtl/codec_sport.sv
module codec_sport
  import codec_sp_pkg::*;
#(
  parameter int EVT_DIV = 256
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] adc_word_i,
  input  logic              sdi_i,
  output logic              adc_strobe_o,
  output logic              sclk_o,
  output logic              fs_o,
  output logic              sdo_o,
  output logic [WORD_W-1:0] dac_data_o,
  output logic              dac_valid_o,
  output logic [1:0]        mode_o,
  output logic [1:0]        sclk_sel_o,
  output logic [2:0]        mdiv_code_o
);
  logic              evt;
  logic              sclk_tick;
  logic [WORD_W-1:0] rx_word;
  logic              rx_valid;

  codec_sp_clkgen #(.EVT_DIV(EVT_DIV)) i_clkgen (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mdiv_code_i (mdiv_code_o),
    .sclk_sel_i  (sclk_sel_o),
    .evt_o       (evt),
    .sclk_tick_o (sclk_tick)
  );

  codec_sp_shifter #(.W(WORD_W)) i_shifter (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .evt_i       (evt),
    .sclk_tick_i (sclk_tick),
    .adc_i       (adc_word_i),
    .sdi_i       (sdi_i),
    .fs_o        (fs_o),
    .sdo_o       (sdo_o),
    .rx_word_o   (rx_word),
    .rx_valid_o  (rx_valid)
  );

  codec_sp_router #(.W(WORD_W)) i_router (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rx_word_i   (rx_word),
    .rx_valid_i  (rx_valid),
    .mode_o      (mode_o),
    .sclk_sel_o  (sclk_sel_o),
    .mdiv_code_o (mdiv_code_o),
    .dac_data_o  (dac_data_o),
    .dac_valid_o (dac_valid_o)
  );

  assign adc_strobe_o = evt;
  assign sclk_o       = sclk_tick;
endmodule

// File: tb/test_codec_sport.sv
module test_codec_sport;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] adc_word = 16'h0;
  logic        sdi = 1'b0;
  logic        adc_strobe, sclk, fs, sdo, dac_valid;
  logic [15:0] dac_data;
  logic [1:0]  mode, sclk_sel;
  logic [2:0]  mdiv_code;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int dac_cnt = 0;
  logic [15:0] last_dac = 16'h0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (dac_valid) begin
    dac_cnt  = dac_cnt + 1;
    last_dac = dac_data;
  end

  codec_sport i_codec_sport (
    .clk_i(clk), .rst_ni(rst_n), .adc_word_i(adc_word), .sdi_i(sdi),
    .adc_strobe_o(adc_strobe), .sclk_o(sclk), .fs_o(fs), .sdo_o(sdo),
    .dac_data_o(dac_data), .dac_valid_o(dac_valid), .mode_o(mode),
    .sclk_sel_o(sclk_sel), .mdiv_code_o(mdiv_code)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // runs one frame: returns word seen on sdo and spacing of first two bit strobes
  task automatic frame(input logic [15:0] tx, output logic [15:0] rx, output int gap);
    int t0;
    logic [15:0] sent;
    @(negedge clk);
    while (!(fs && sclk)) @(negedge clk);
    sent = adc_word;
    adc_word = ~sent;  // must not leak into this frame (R4)
    t0 = 0;
    gap = 0;
    for (int i = 15; i >= 0; i--) begin
      @(negedge clk);
      while (!sclk) @(negedge clk);
      rx[i] = sdo;
      sdi = tx[i];
      if (i == 15) t0 = cyc;
      if (i == 14) gap = cyc - t0;
    end
    repeat (3) @(negedge clk);
    adc_word = sent;
  endtask

  task automatic evt_gap(output int gap);
    int t0;
    @(negedge clk);
    while (!adc_strobe) @(negedge clk);
    t0 = cyc;
    @(negedge clk);
    while (!adc_strobe) @(negedge clk);
    gap = cyc - t0;
  endtask

  function automatic int nratio(input int code);
    return (code >= 1 && code <= 4) ? code + 1 : 1;
  endfunction

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] rx, adc_v, w;
    int gap, n0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(mode == 2'b00, "R1 mode", mode, 0);
    check(sclk_sel == 2'b00, "R1 sclk_sel", sclk_sel, 0);
    check(mdiv_code == 3'd0, "R1 mdiv", mdiv_code, 0);
    check(!fs && !dac_valid, "R1 fs/valid", {fs, dac_valid}, 0);
    check(dac_data == 16'h0, "R1 dac", dac_data, 0);
    rst_n = 1'b1;

    // R6: write to unused select 2 changes nothing
    adc_word = 16'hA5C3;
    frame(16'h02FF, rx, gap);
    check(rx == 16'hA5C3, "R4 tx word", rx, 16'hA5C3);
    check(mode == 0 && sclk_sel == 0 && mdiv_code == 0, "R6 ignored select",
          {mode, sclk_sel, mdiv_code}, 0);
    check(dac_cnt == 0, "R6 no dac", dac_cnt, 0);

    // sweep all divider codes and rate selects
    for (int c = 0; c < 8; c++) begin
      for (int s = 0; s < 4; s++) begin
        w = {5'b0, 3'd1, 1'b0, 3'(c), 2'(s), 2'b00};
        frame(w, rx, gap);
        check(mdiv_code == 3'(c), "R6 mdiv field", mdiv_code, c);
        check(sclk_sel == 2'(s), "R6 sclk field", sclk_sel, s);
        adc_v = 16'(c * 4099 + s * 521 + 16'h1234);
        adc_word = adc_v;
        frame(16'h0355, rx, gap);
        check(rx == adc_v, "R4 tx word", rx, adc_v);
        check(gap == nratio(c) * (1 << s), "R3 bit spacing", gap, nratio(c) * (1 << s));
        check(mode == 0 && dac_cnt == 0, "R6 ignored select", {mode, 8'(dac_cnt)}, 0);
        if (s == 0) begin
          evt_gap(gap);
          check(gap == 256 * nratio(c), "R2 event spacing", gap, 256 * nratio(c));
        end
      end
    end

    // back to fast clocks, then R5 receive path via control write to mode
    frame(16'h0100, rx, gap);
    frame(16'h0003, rx, gap);
    check(mode == 2'b11, "R5 rx word -> mode", mode, 3);

    // R8 mixed mode
    n0 = dac_cnt;
    frame(16'h4321, rx, gap);
    check(dac_cnt == n0 + 1 && last_dac == 16'h8642, "R8 mixed data", last_dac, 16'h8642);
    frame(16'h7FFF, rx, gap);
    check(last_dac == 16'hFFFE, "R8 mixed data lsb", last_dac, 16'hFFFE);
    n0 = dac_cnt;
    frame(16'h8104, rx, gap);
    check(sclk_sel == 2'd1 && mdiv_code == 0, "R8 mixed ctrl", {sclk_sel, mdiv_code}, 8);
    check(dac_cnt == n0, "R8 ctrl no dac", dac_cnt, n0);
    frame(16'h8001, rx, gap);
    check(mode == 2'b01, "R8 mixed ctrl mode", mode, 1);

    // R7 data mode
    foreach (w[i]) ;
    n0 = dac_cnt;
    frame(16'h8001, rx, gap);
    check(last_dac == 16'h8001 && dac_cnt == n0 + 1, "R7 data word", last_dac, 16'h8001);
    frame(16'h0102, rx, gap);
    check(last_dac == 16'h0102, "R7 data word", last_dac, 16'h0102);
    check(mode == 1 && sclk_sel == 1 && mdiv_code == 0, "R7 regs hold",
          {mode, sclk_sel, mdiv_code}, 8'b01_01_000);
    frame(16'h0000, rx, gap);
    check(last_dac == 16'h0000 && mode == 1, "R7 data zero", last_dac, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule